// File: doc/BRIEF.md
# Segmented Pulse-Width Wordline Sequencer

This block turns a vector of parallel 8-bit activations into timed wordline enables for a compute-in-memory array. Each activation is split into a 2-bit upper field, a 3-bit middle field and a 3-bit lower field. Each field is played out in a phase of its own as one contiguous pulse whose length in clock cycles equals the field value. Every row is driven in the same phase at the same time, so any number of wordlines can be active together on a shared column.

The phases run from the upper field to the lower field, and each has a fixed length that does not depend on the data. After the upper phase the block strobes the column converters to sample and then to clear. After the middle phase it only strobes them to hold, so charge keeps accumulating. After the lower phase it strobes a final sample, and a one-cycle done pulse follows. A scale-select output gives the downstream accumulator the bit count n of the field in flight, so that field can be weighted by 1/2^n.

Activations enter through a valid/ready port. `in_ready` is high only while the block is idle. A vector is taken on a clock edge where `in_valid` and `in_ready` are both high. The source must hold `in_data` steady while `in_valid` is high and `in_ready` is low. Valid requests during a run are not accepted and have no effect on that run. The outputs are plain strobes and levels and cannot be back-pressured.

Top module: `cim_pulse_seq`

## Requirements
- R1: Row r takes its activation from `in_data[8r+7:8r]`. The upper field is bits 7:6, the middle field bits 5:3 and the lower field bits 2:0. The phases run upper, middle, lower, and `phase` reads 1, 2 and 3 through each field's pulse and strobe cycles, and 0 when idle or done.
- R2: In each phase a row's wordline goes high in the first cycle of the pulse window and stays high for exactly as many cycles as the field value, with no gaps. A field of zero keeps the wordline low.
- R3: The pulse windows last 3, 7 and 7 cycles whatever the data, and all rows are driven in parallel.
- R4: The upper pulse window is followed by one cycle of `sample_strb` and then one cycle of `clear_strb`. All wordlines are low in every strobe cycle.
- R5: The middle pulse window is followed by one cycle of `hold_strb` with no clear, and the lower window by one cycle of `sample_strb`. `clear_strb` appears only directly after the first sample.
- R6: `scale_sel` reads 3 (weight 1/8) during the middle and lower phases, strobe cycles included, and 0 at all other times.
- R7: `done` is high for exactly one cycle, the cycle after the final sample, while `busy` is still high. In the next cycle the block is idle with `in_ready` high.
- R8: `in_ready` is high only while idle. Data is captured on a cycle where `in_valid` and `in_ready` are both high, and `busy` rises in the next cycle. A valid request during a run does not change that run's wordlines.
- R9: A synchronous active-high `rst` returns the block to idle from any state: wordlines low, strobes low, `busy` low, `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Activation vector offered |
| in_ready | output | 1 | Block idle and able to take a vector |
| in_data | input | ROWS*8 | Packed activations, row 0 in the low byte |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| wl_en | output | ROWS | Per-row wordline enables |
| phase | output | 2 | Field in progress: 0 none, 1 upper, 2 middle, 3 lower |
| sample_strb | output | 1 | Converters sample the column |
| clear_strb | output | 1 | Converters clear the column |
| hold_strb | output | 1 | Converters hold and keep accumulating |
| scale_sel | output | 2 | Bit count n of the field in flight, for 1/2^n weighting |

## Verification
The assertions assume a clean start under reset and a source that never needs its vector taken during a run. Under that assumption the one-strobe-per-cycle and ordering properties (clear only after the first sample, done only after a sample) hold on every cycle. The bench offers vectors only from idle. It raises `in_valid` mid-run on purpose, with a different vector, to show that the run in progress is not disturbed, and it drops the request before the block returns to idle. The wordline-rise property takes for granted that a pulse begins only on a phase boundary. The zero, all-ones and mixed vectors exercise both the empty and the full-window pulse.

// File: rtl/cim_seq_pkg.sv
package cim_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_P_HI,
    ST_SAMP_HI,
    ST_CLR_HI,
    ST_P_MID,
    ST_HOLD_MID,
    ST_P_LO,
    ST_SAMP_LO,
    ST_DONE
  } seq_state_t;

  localparam logic [1:0] PH_NONE = 2'd0;
  localparam logic [1:0] PH_HI   = 2'd1;
  localparam logic [1:0] PH_MID  = 2'd2;
  localparam logic [1:0] PH_LO   = 2'd3;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cim_seq_ctrl.sv
module cim_seq_ctrl
  import cim_seq_pkg::*;
#(
  parameter int HI_W  = 2,
  parameter int MID_W = 3,
  parameter int LO_W  = 3,
  parameter int CNT_W = 3,
  parameter int SCL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             capture,
  output logic             busy,
  output logic             done,
  output logic             pulse_act,
  output logic [1:0]       phase,
  output logic [CNT_W-1:0] cnt,
  output logic             sample_strb,
  output logic             clear_strb,
  output logic             hold_strb,
  output logic [SCL_W-1:0] scale_sel
);

  localparam int HI_LAST  = (1 << HI_W) - 2;
  localparam int MID_LAST = (1 << MID_W) - 2;
  localparam int LO_LAST  = (1 << LO_W) - 2;

  seq_state_t state, state_nx;
  logic [CNT_W-1:0] cnt_nx;

  assign in_ready = (state == ST_IDLE);
  assign capture  = in_valid && in_ready;

  always_comb begin
    state_nx = state;
    cnt_nx   = '0;
    unique case (state)
      ST_IDLE:     if (capture) state_nx = ST_P_HI;
      ST_P_HI: begin
        if (int'(cnt) >= HI_LAST) state_nx = ST_SAMP_HI;
        else cnt_nx = cnt + 1'b1;
      end
      ST_SAMP_HI:  state_nx = ST_CLR_HI;
      ST_CLR_HI:   state_nx = ST_P_MID;
      ST_P_MID: begin
        if (int'(cnt) >= MID_LAST) state_nx = ST_HOLD_MID;
        else cnt_nx = cnt + 1'b1;
      end
      ST_HOLD_MID: state_nx = ST_P_LO;
      ST_P_LO: begin
        if (int'(cnt) >= LO_LAST) state_nx = ST_SAMP_LO;
        else cnt_nx = cnt + 1'b1;
      end
      ST_SAMP_LO:  state_nx = ST_DONE;
      ST_DONE:     state_nx = ST_IDLE;
      default:     state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      cnt   <= cnt_nx;
    end
  end

  always_comb begin
    unique case (state)
      ST_P_HI, ST_SAMP_HI, ST_CLR_HI: phase = PH_HI;
      ST_P_MID, ST_HOLD_MID:          phase = PH_MID;
      ST_P_LO, ST_SAMP_LO:            phase = PH_LO;
      default:                        phase = PH_NONE;
    endcase
  end

  always_comb begin
    unique case (phase)
      PH_MID:  scale_sel = SCL_W'(MID_W);
      PH_LO:   scale_sel = SCL_W'(LO_W);
      default: scale_sel = '0;
    endcase
  end

  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_DONE);
  assign pulse_act   = (state == ST_P_HI) || (state == ST_P_MID) || (state == ST_P_LO);
  assign sample_strb = (state == ST_SAMP_HI) || (state == ST_SAMP_LO);
  assign clear_strb  = (state == ST_CLR_HI);
  assign hold_strb   = (state == ST_HOLD_MID);

endmodule

// File: rtl/cim_in_latch.sv
module cim_in_latch #(
  parameter int ROWS   = 4,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   capture,
  input  logic [ROWS*DATA_W-1:0] d_in,
  output logic [ROWS*DATA_W-1:0] d_q
);

  always_ff @(posedge clk) begin
    if (rst)          d_q <= '0;
    else if (capture) d_q <= d_in;
  end

endmodule

// File: rtl/cim_wl_row.sv
module cim_wl_row
  import cim_seq_pkg::*;
#(
  parameter int HI_W  = 2,
  parameter int MID_W = 3,
  parameter int LO_W  = 3,
  parameter int CNT_W = 3
) (
  input  logic                        pulse_act,
  input  logic [1:0]                  phase,
  input  logic [CNT_W-1:0]            cnt,
  input  logic [HI_W+MID_W+LO_W-1:0]  act,
  output logic                        wl
);

  localparam int DATA_W = HI_W + MID_W + LO_W;

  logic [CNT_W-1:0] seg;

  always_comb begin
    unique case (phase)
      PH_HI:   seg = CNT_W'(act[DATA_W-1 -: HI_W]);
      PH_MID:  seg = CNT_W'(act[LO_W +: MID_W]);
      PH_LO:   seg = CNT_W'(act[LO_W-1:0]);
      default: seg = '0;
    endcase
  end

  assign wl = pulse_act && (cnt < seg);

endmodule

// File: rtl/cim_pulse_seq.sv
module cim_pulse_seq
  import cim_seq_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int HI_W  = 2,
  parameter int MID_W = 3,
  parameter int LO_W  = 3
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [ROWS*(HI_W+MID_W+LO_W)-1:0]   in_data,
  output logic                                busy,
  output logic                                done,
  output logic [ROWS-1:0]                     wl_en,
  output logic [1:0]                          phase,
  output logic                                sample_strb,
  output logic                                clear_strb,
  output logic                                hold_strb,
  output logic [$clog2(max3(HI_W, MID_W, LO_W)+1)-1:0] scale_sel
);

  localparam int DATA_W = HI_W + MID_W + LO_W;
  localparam int CNT_W  = max3(HI_W, MID_W, LO_W);
  localparam int SCL_W  = $clog2(CNT_W + 1);

  logic                   capture;
  logic                   pulse_act;
  logic [CNT_W-1:0]       cnt;
  logic [ROWS*DATA_W-1:0] act_q;

  cim_seq_ctrl #(
    .HI_W(HI_W), .MID_W(MID_W), .LO_W(LO_W), .CNT_W(CNT_W), .SCL_W(SCL_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .capture(capture), .busy(busy), .done(done), .pulse_act(pulse_act),
    .phase(phase), .cnt(cnt), .sample_strb(sample_strb),
    .clear_strb(clear_strb), .hold_strb(hold_strb), .scale_sel(scale_sel)
  );

  cim_in_latch #(.ROWS(ROWS), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .capture(capture), .d_in(in_data), .d_q(act_q)
  );

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    cim_wl_row #(
      .HI_W(HI_W), .MID_W(MID_W), .LO_W(LO_W), .CNT_W(CNT_W)
    ) u_row (
      .pulse_act(pulse_act), .phase(phase), .cnt(cnt),
      .act(act_q[g*DATA_W +: DATA_W]), .wl(wl_en[g])
    );
  end

endmodule

// File: rtl/cim_pulse_seq_chk.sv
module cim_pulse_seq_chk #(
  parameter int ROWS  = 4,
  parameter int SCL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             busy,
  input logic             done,
  input logic [ROWS-1:0]  wl_en,
  input logic [1:0]       phase,
  input logic             sample_strb,
  input logic             clear_strb,
  input logic             hold_strb,
  input logic [SCL_W-1:0] scale_sel
);

  // R2: a wordline rises only on the first cycle of a phase
  for (genvar i = 0; i < ROWS; i++) begin : g_rise
    a_r2_rise_at_phase_start: assert property (@(posedge clk) disable iff (rst)
      $rose(wl_en[i]) |-> (phase != $past(phase)));
  end

  // R4: wordlines are low in every strobe cycle
  a_r4_strobe_wl_off: assert property (@(posedge clk) disable iff (rst)
    (sample_strb || clear_strb || hold_strb) |-> (wl_en == '0));

  // R4: the upper-field sample is followed by a clear
  a_r4_sample_then_clear: assert property (@(posedge clk) disable iff (rst)
    (sample_strb && phase == 2'd1) |=> clear_strb);

  // R5: a clear only directly follows the first sample
  a_r5_clear_after_first_sample: assert property (@(posedge clk) disable iff (rst)
    clear_strb |-> ($past(sample_strb) && $past(phase) == 2'd1));

  // R5: at most one converter strobe or done per cycle
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sample_strb, clear_strb, hold_strb, done}));

  // R6: scale select only in the middle and lower phases
  a_r6_scale_phase: assert property (@(posedge clk) disable iff (rst)
    (scale_sel != '0) |-> (phase >= 2'd2));

  // R7: done follows the final sample
  a_r7_done_after_sample: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(sample_strb) && $past(phase) == 2'd3));

  // R8: an accepted request starts a run
  a_r8_accept_starts: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (busy && phase == 2'd1));

  // R8: no acceptance while busy
  a_r8_ready_idle: assert property (@(posedge clk) disable iff (rst)
    busy |-> !in_ready);

endmodule

bind cim_pulse_seq cim_pulse_seq_chk #(.ROWS(ROWS), .SCL_W(SCL_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .busy(busy), .done(done), .wl_en(wl_en), .phase(phase),
  .sample_strb(sample_strb), .clear_strb(clear_strb),
  .hold_strb(hold_strb), .scale_sel(scale_sel)
);

// File: tb/test_cim_pulse_seq.sv
module test_cim_pulse_seq;

  localparam int ROWS = 4;
  localparam int NV   = 5;
  localparam logic [31:0] VEC [NV] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h0180_7FC5, 32'hA53C_12E9, 32'h4008_0149
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, busy, done, sample_strb, clear_strb, hold_strb;
  logic [ROWS-1:0] wl_en;
  logic [1:0] phase, scale_sel;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  cim_pulse_seq #(.ROWS(ROWS)) i_cim_pulse_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .busy(busy), .done(done), .wl_en(wl_en),
    .phase(phase), .sample_strb(sample_strb), .clear_strb(clear_strb),
    .hold_strb(hold_strb), .scale_sel(scale_sel)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(wl_en == '0 && !busy && in_ready && !done && !sample_strb && !clear_strb
        && !hold_strb && phase == 2'd0,
        req, {wl_en, busy, in_ready, done, sample_strb, clear_strb, hold_strb, phase},
        {4'b0, 1'b0, 1'b1, 4'b0, 2'b0});
  endtask

  // Run one vector; when poke is set, offer a different vector mid-run.
  task automatic run_vec(input logic [31:0] v, input bit poke);
    int cnt_row [ROWS][4];
    int col [4];
    int shape_err, strb_err, hs_err, ph_err;
    shape_err = 0; strb_err = 0; hs_err = 0; ph_err = 0;
    for (int r = 0; r < ROWS; r++)
      for (int p = 0; p < 4; p++) cnt_row[r][p] = 0;
    for (int p = 0; p < 4; p++) col[p] = 0;

    @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
    @(posedge clk);
    for (int k = 1; k <= 23; k++) begin
      @(negedge clk);
      if (k == 1) in_valid = 1'b0;
      if (poke && k >= 7 && k <= 9) begin in_valid = 1'b1; in_data = ~v; end
      if (poke && k == 10) in_valid = 1'b0;
      for (int r = 0; r < ROWS; r++) begin
        int hi, mid, lo;
        bit ew;
        hi  = int'(v[r*8+6 +: 2]);
        mid = int'(v[r*8+3 +: 3]);
        lo  = int'(v[r*8   +: 3]);
        ew  = (k >= 1 && k <= 3   && (k - 1)  < hi) ||
              (k >= 6 && k <= 12  && (k - 6)  < mid) ||
              (k >= 14 && k <= 20 && (k - 14) < lo);
        if (wl_en[r] !== ew) shape_err++;
        if (wl_en[r]) begin
          cnt_row[r][phase]++;
          col[phase]++;
        end
      end
      // R4 R5 strobe placement
      if (sample_strb !== (k == 4 || k == 21)) strb_err++;
      if (clear_strb  !== (k == 5)) strb_err++;
      if (hold_strb   !== (k == 13)) strb_err++;
      // R7 R8 completion and handshake
      if (done     !== (k == 22)) hs_err++;
      if (busy     !== (k <= 22)) hs_err++;
      if (in_ready !== (k == 23)) hs_err++;
      // R1 R3 R6 phase sequence and scale
      if (phase !== ((k <= 5) ? 2'd1 : (k <= 13) ? 2'd2 : (k <= 21) ? 2'd3 : 2'd0)) ph_err++;
      if (scale_sel !== ((k >= 6 && k <= 21) ? 2'd3 : 2'd0)) ph_err++;
    end

    for (int r = 0; r < ROWS; r++) begin
      int got;
      got = cnt_row[r][1] * 64 + cnt_row[r][2] * 8 + cnt_row[r][3];
      chk(got == int'(v[r*8 +: 8]), poke ? "R8 ignored mid-run request" : "R1 row value",
          got, int'(v[r*8 +: 8]));
    end
    begin
      int acc, ref_sum;
      acc = col[1] * 64 + col[2] * 8 + col[3];
      ref_sum = 0;
      for (int r = 0; r < ROWS; r++) ref_sum += int'(v[r*8 +: 8]);
      chk(acc == ref_sum, "R3 column sum", acc, ref_sum);
    end
    chk(shape_err == 0, "R2 pulse shape", shape_err, 0);
    chk(strb_err == 0, "R4 R5 strobes", strb_err, 0);
    chk(hs_err == 0, "R7 done/handshake", hs_err, 0);
    chk(ph_err == 0, "R6 phase/scale", ph_err, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_idle("R9 reset state");

    for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0);

    // R8: request during busy ignored
    run_vec(32'h6B_92_37_D4, 1'b1);

    // R9: reset mid-run
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 32'hFFFF_FFFF;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk(busy && wl_en != '0, "R9 run active before reset", {busy, wl_en}, 5'b11111);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_idle("R9 mid-run reset");

    run_vec(32'h3C_C3_81_18, 1'b0);

    finish_run();
  end

endmodule